// File: doc/BRIEF.md
# Parallel Bus Burst Initiator

This block is the initiator side of a shared, multiplexed address/data bus whose control lines are active low and sampled on rising clock edges. A back end hands it one request at a time: a 4-bit command, a start address and a burst length in words. The engine then drives a single burst on the bus. It starts with an address phase that carries the command on the command/byte-enable lanes. One or more data phases follow. Each carries byte enables and, on writes, the data word. The engine releases the frame line early to mark the final phase.

Write data and byte enables come from the back end one beat at a time through a take strobe. Read words are returned with a one-cycle valid pulse. The bus is driven through separate output values and output enables, so the pad ring can build the bidirectional pins. Parity covering the driven address/data and command/enable lanes goes out one clock behind the lanes it covers.

The engine watches the target's responses on every data phase: claim, ready and stop. It reports how the burst ended with a status code and the count of words actually moved. The possible endings are normal completion, retry, disconnect with data, disconnect without data, target abort and master abort (no claim inside the decode window). After any ending it drives the control lines high for one clock and then lets them float.

Top module: `pbus_initiator`

## Requirements
- R1: While reset is held and right after it, frame_n_o and irdy_n_o are 1, ctl_oe, ad_oe and par_oe are 0, done is 0 and req_ready is 1.
- R2: A burst starts only at an edge where the engine is idle, req_valid is 1, gnt_n is 0 and both frame_n_i and irdy_n_i are 1. In the next cycle (the address phase) frame_n_o=0, irdy_n_o=1, ctl_oe=1, ad_oe=1, ad_o=req_addr and cbe_n_o=req_cmd.
- R3: In every data phase irdy_n_o=0 and cbe_n_o is the bitwise inverse of the beat's beat_be, where bit i enables byte lane ad[8i+7:8i]. For a write command (req_cmd bit 0 = 1, e.g. 0011, 0111, 1011) ad_oe=1 and ad_o is the beat's data. For a read command (bit 0 = 0, e.g. 0010, 0110, 1010) ad_oe=0.
- R4: A word moves only at an edge in a data phase where irdy_n_o, trdy_n_i and devsel_n_i are all 0. beat_take is 1 combinationally in the address phase, and in a data phase where a word moves, more words remain and stop_n_i is 1.
- R5: frame_n_o is 1 in exactly the data phases where one word remains, and irdy_n_o stays 0 until that word moves or the burst is terminated.
- R6: When the last word moves, the next cycle shows frame_n_o=1, irdy_n_o=1, done=1, done_code=0 (complete) and done_count=req_len, with ctl_oe still 1. In the cycle after that, ctl_oe=0 and req_ready=1. This holds even if stop_n_i is 0 on that last transfer.
- R7: par_oe is the one-cycle-delayed ad_oe. When par_oe is 1, the XOR of par_o with the previous cycle's ad_o and cbe_n_o is 0.
- R8: If devsel_n_i is 1 at each of the first four edges after the address phase, the burst ends with done_code=5 (master abort) and done_count=0.
- R9: stop_n_i=0 with devsel_n_i=0 and trdy_n_i=1 before any word has moved ends the burst with done_code=1 (retry) and done_count=0.
- R10: stop_n_i=0 with devsel_n_i=0 and trdy_n_i=0 on a word that is not the last moves that word and ends the burst with done_code=2 (disconnect with data).
- R11: stop_n_i=0 with devsel_n_i=0 and trdy_n_i=1 after at least one word has moved ends the burst with done_code=3 (disconnect without data) and done_count equal to the words moved.
- R12: stop_n_i=0 with devsel_n_i=1 after the target has claimed the burst ends it with done_code=4 (target abort) and done_count equal to the words moved.
- R13: A termination decided while frame_n_o is 0 is followed by one cycle with frame_n_o=1 and irdy_n_o=0, then one cycle with both at 1. A termination decided while frame_n_o is already 1 goes straight to the cycle with both at 1.
- R14: For a read, rd_valid is 1 in the cycle after each edge where a word moves, and rd_data holds the ad_i value sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Back end offers a burst |
| req_cmd | input | 4 | Bus command for the address phase |
| req_addr | input | DATA_W | Start address |
| req_len | input | LEN_W | Burst length in words (0 is treated as 1) |
| req_ready | output | 1 | Engine idle and able to accept a burst |
| beat_data | input | DATA_W | Write data of the head beat |
| beat_be | input | DATA_W/8 | Active-high byte enables of the head beat |
| beat_take | output | 1 | Head beat is consumed at this edge |
| rd_valid | output | 1 | Read word on rd_data |
| rd_data | output | DATA_W | Captured read word |
| done | output | 1 | One-cycle end-of-burst pulse |
| done_code | output | 3 | 0 complete, 1 retry, 2 disconnect with data, 3 disconnect without data, 4 target abort, 5 master abort |
| done_count | output | LEN_W | Words actually moved |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n_i | input | 1 | Observed frame line of the shared bus |
| irdy_n_i | input | 1 | Observed initiator-ready line of the shared bus |
| devsel_n_i | input | 1 | Target claim, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| stop_n_i | input | 1 | Target termination request, active low |
| ad_i | input | DATA_W | Address/data lanes as seen on the bus |
| frame_n_o | output | 1 | Frame drive value |
| irdy_n_o | output | 1 | Initiator-ready drive value |
| ctl_oe | output | 1 | Enable for frame, initiator-ready and command/enable lanes |
| ad_o | output | DATA_W | Address/data drive value |
| cbe_n_o | output | DATA_W/8 | Command or active-low byte enables |
| ad_oe | output | 1 | Enable for the address/data lanes |
| par_o | output | 1 | Even parity of the previous cycle's lanes |
| par_oe | output | 1 | Enable for parity |

## Verification
The bench builds the block with its defaults: a 32-bit datapath, an 8-bit length and a four-edge decode window. With those values the whole claim window, including the abort on the fourth edge, is reached inside short bursts. The bursts are kept to five words or fewer, so every ending can be placed on the first, a middle or the last word. They include a single-word burst whose frame is already released when a master abort strikes, and a stop that coincides with the final transfer.

// File: rtl/pbi_pkg.sv
package pbi_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_DATA = 3'd2,
    PH_REL  = 3'd3,
    PH_END  = 3'd4
  } phase_t;

  typedef enum logic [2:0] {
    END_DONE      = 3'd0,
    END_RETRY     = 3'd1,
    END_DISC_DATA = 3'd2,
    END_DISC_NONE = 3'd3,
    END_TGT_ABORT = 3'd4,
    END_MST_ABORT = 3'd5
  } end_code_t;

  // Command bit 0 separates writes (1) from reads (0).
  function automatic logic cmd_writes(input logic [3:0] cmd);
    return cmd[0];
  endfunction

endpackage

// File: rtl/pbi_beat_cnt.sv
module pbi_beat_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step,
  output logic [LEN_W-1:0] rem_o,
  output logic [LEN_W-1:0] moved_o,
  output logic             last_o,
  output logic             two_left_o
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_o   <= '0;
      moved_o <= '0;
    end else if (load) begin
      rem_o   <= (len_i == '0) ? ONE : len_i;
      moved_o <= '0;
    end else if (step) begin
      rem_o   <= rem_o - ONE;
      moved_o <= moved_o + ONE;
    end
  end

  assign last_o     = (rem_o == ONE);
  assign two_left_o = (rem_o == TWO);

  // R4
  rem_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> rem_o != '0);

endmodule

// File: rtl/pbi_claim_watch.sv
module pbi_claim_watch #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic active,
  input  logic devsel_n,
  output logic claimed_o,
  output logic expired_o
);

  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LAST_EDGE = CW'(WIN - 1);

  logic [CW-1:0] edges;

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      edges     <= '0;
      claimed_o <= 1'b0;
    end else if (active) begin
      if (!devsel_n) claimed_o <= 1'b1;
      if (!claimed_o && edges != LAST_EDGE) edges <= edges + CW'(1);
    end
  end

  assign expired_o = active && !claimed_o && devsel_n && (edges == LAST_EDGE);

  // R8
  win_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !claimed_o) |-> edges <= LAST_EDGE);

endmodule

// File: rtl/pbi_parity.sv
module pbi_parity #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                drive_i,
  input  logic [DATA_W-1:0]   ad_i,
  input  logic [DATA_W/8-1:0] cbe_n_i,
  output logic                par_o,
  output logic                par_oe_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_o    <= ^{ad_i, cbe_n_i};
      par_oe_o <= drive_i;
    end
  end

  // R7
  par_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(par_oe_o) |-> $past(drive_i));

endmodule

// File: rtl/pbus_initiator.sv
module pbus_initiator
  import pbi_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 8,
  parameter int DEC_WIN = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [3:0]          req_cmd,
  input  logic [DATA_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  output logic                req_ready,
  input  logic [DATA_W-1:0]   beat_data,
  input  logic [DATA_W/8-1:0] beat_be,
  output logic                beat_take,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                done,
  output logic [2:0]          done_code,
  output logic [LEN_W-1:0]    done_count,
  input  logic                gnt_n,
  input  logic                frame_n_i,
  input  logic                irdy_n_i,
  input  logic                devsel_n_i,
  input  logic                trdy_n_i,
  input  logic                stop_n_i,
  input  logic [DATA_W-1:0]   ad_i,
  output logic                frame_n_o,
  output logic                irdy_n_o,
  output logic                ctl_oe,
  output logic [DATA_W-1:0]   ad_o,
  output logic [DATA_W/8-1:0] cbe_n_o,
  output logic                ad_oe,
  output logic                par_o,
  output logic                par_oe
);

  localparam int BE_W = DATA_W / 8;

  phase_t     st;
  logic       cmd_wr;
  logic       start, in_data, xfer, stop_req, tgt_abort, mst_abort;
  logic       finish_ok, end_any;
  logic       claimed, last, two_left;
  logic [LEN_W-1:0] rem, moved;
  end_code_t  end_c;

  assign start     = (st == PH_IDLE) && req_valid && !gnt_n && frame_n_i && irdy_n_i;
  assign in_data   = (st == PH_DATA);
  assign xfer      = in_data && !irdy_n_o && !trdy_n_i && !devsel_n_i;
  assign stop_req  = in_data && !devsel_n_i && !stop_n_i;
  assign tgt_abort = in_data && claimed && devsel_n_i && !stop_n_i;
  assign finish_ok = xfer && last;
  assign end_any   = tgt_abort || mst_abort || finish_ok || stop_req;
  assign req_ready = (st == PH_IDLE);
  assign beat_take = (st == PH_ADDR) || (xfer && !last && stop_n_i);

  pbi_beat_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .load(start), .len_i(req_len), .step(xfer),
    .rem_o(rem), .moved_o(moved), .last_o(last), .two_left_o(two_left)
  );

  pbi_claim_watch #(.WIN(DEC_WIN)) u_claim (
    .clk(clk), .rst(rst), .arm(start), .active(in_data),
    .devsel_n(devsel_n_i), .claimed_o(claimed), .expired_o(mst_abort)
  );

  pbi_parity #(.DATA_W(DATA_W)) u_par (
    .clk(clk), .rst(rst), .drive_i(ad_oe), .ad_i(ad_o), .cbe_n_i(cbe_n_o),
    .par_o(par_o), .par_oe_o(par_oe)
  );

  // Ending priority: target abort, master abort, final word, stop.
  always_comb begin
    if (tgt_abort)          end_c = END_TGT_ABORT;
    else if (mst_abort)     end_c = END_MST_ABORT;
    else if (finish_ok)     end_c = END_DONE;
    else if (xfer)          end_c = END_DISC_DATA;
    else if (moved == '0)   end_c = END_RETRY;
    else                    end_c = END_DISC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      frame_n_o  <= 1'b1;
      irdy_n_o   <= 1'b1;
      ctl_oe     <= 1'b0;
      ad_oe      <= 1'b0;
      ad_o       <= '0;
      cbe_n_o    <= '1;
      cmd_wr     <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      done       <= 1'b0;
      done_code  <= '0;
      done_count <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= xfer && !cmd_wr;
      if (xfer && !cmd_wr) rd_data <= ad_i;
      unique case (st)
        PH_IDLE: if (start) begin
          st        <= PH_ADDR;
          frame_n_o <= 1'b0;
          irdy_n_o  <= 1'b1;
          ctl_oe    <= 1'b1;
          ad_oe     <= 1'b1;
          ad_o      <= req_addr;
          cbe_n_o   <= req_cmd[BE_W-1:0];
          cmd_wr    <= cmd_writes(req_cmd);
        end
        PH_ADDR: begin
          st        <= PH_DATA;
          irdy_n_o  <= 1'b0;
          frame_n_o <= last;
          ad_o      <= beat_data;
          cbe_n_o   <= ~beat_be;
          ad_oe     <= cmd_wr;
        end
        PH_DATA: begin
          if (end_any) begin
            st         <= frame_n_o ? PH_END : PH_REL;
            frame_n_o  <= 1'b1;
            irdy_n_o   <= frame_n_o;
            ad_oe      <= 1'b0;
            done       <= 1'b1;
            done_code  <= end_c;
            done_count <= moved + LEN_W'(xfer);
          end else if (xfer) begin
            ad_o      <= beat_data;
            cbe_n_o   <= ~beat_be;
            frame_n_o <= two_left;
          end
        end
        PH_REL: begin
          st       <= PH_END;
          irdy_n_o <= 1'b1;
        end
        PH_END: begin
          st     <= PH_IDLE;
          ctl_oe <= 1'b0;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (frame_n_o && irdy_n_o && !ctl_oe && !done));
  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_oe) |-> $past(req_valid && !gnt_n && frame_n_i && irdy_n_i));
  // R5
  frame_last_chk: assert property (@(posedge clk) disable iff (rst)
    (in_data && frame_n_o) |-> last);
  // R6
  done_released_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (frame_n_o && ctl_oe && !ad_oe));
  // R7
  even_par_chk: assert property (@(posedge clk) disable iff (rst)
    par_oe |-> ((par_o ^ (^{$past(ad_o), $past(cbe_n_o)})) == 1'b0));
  // R8
  mabort_count_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_code == 3'd5) |-> done_count == '0);
  // R13
  release_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == PH_REL) |-> (frame_n_o && !irdy_n_o) ##1 (frame_n_o && irdy_n_o));
  // R14
  rd_after_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!trdy_n_i && !devsel_n_i && !irdy_n_o));

endmodule

// File: tb/tb_pbus_initiator.sv
module tb_pbus_initiator;

  localparam int DW = 32;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [3:0]    req_cmd;
  logic [DW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic          req_ready;
  logic [DW-1:0] beat_data;
  logic [3:0]    beat_be;
  logic          beat_take;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          done;
  logic [2:0]    done_code;
  logic [LW-1:0] done_count;
  logic          gnt_n, frame_n_i, irdy_n_i, devsel_n_i, trdy_n_i, stop_n_i;
  logic [DW-1:0] ad_i;
  logic          frame_n_o, irdy_n_o, ctl_oe, ad_oe, par_o, par_oe;
  logic [DW-1:0] ad_o;
  logic [3:0]    cbe_n_o;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pbus_initiator dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready),
    .beat_data(beat_data), .beat_be(beat_be), .beat_take(beat_take),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .done_code(done_code),
    .done_count(done_count), .gnt_n(gnt_n), .frame_n_i(frame_n_i),
    .irdy_n_i(irdy_n_i), .devsel_n_i(devsel_n_i), .trdy_n_i(trdy_n_i),
    .stop_n_i(stop_n_i), .ad_i(ad_i), .frame_n_o(frame_n_o),
    .irdy_n_o(irdy_n_o), .ctl_oe(ctl_oe), .ad_o(ad_o), .cbe_n_o(cbe_n_o),
    .ad_oe(ad_oe), .par_o(par_o), .par_oe(par_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wword(input logic [31:0] a, input int k);
    return (a ^ (32'h01010101 * k)) + 32'(k * 7);
  endfunction
  function automatic logic [3:0] wbe(input int k);
    return 4'((k * 5 + 3) & 15);
  endfunction
  function automatic logic [31:0] rword(input logic [31:0] a, input int k);
    return 32'hA5000000 + {16'h0, a[15:0]} + 32'(k);
  endfunction

  // R7: even parity over the previous cycle's lanes, checked every clock.
  logic [31:0] pad;
  logic [3:0]  pcbe;
  initial begin
    pad = '0; pcbe = '0;
    forever begin
      @(negedge clk);
      if (par_oe === 1'b1)
        chk((par_o ^ (^{pad, pcbe})) == 1'b0, "R7", "parity", {31'd0, par_o}, {31'd0, ^{pad, pcbe}});
      pad = ad_o; pcbe = cbe_n_o;
    end
  end

  task automatic idle_bus();
    devsel_n_i = 1'b1; trdy_n_i = 1'b1; stop_n_i = 1'b1; ad_i = '0;
  endtask

  // One burst, predicted cycle by cycle from the requirements.
  // dly: data cycle where the target claims (99 = never); waitm: ready on
  // alternate cycles; stop_at: words moved when stop rises (-1 none).
  task automatic run_txn(input logic [3:0] cmd, input logic [31:0] addr, input int len,
                         input int dly, input bit waitm, input int stop_at,
                         input bit stop_data, input bit tab,
                         input int exp_code, input int exp_cnt, input string req);
    bit wr = cmd[0];
    int moved = 0, rem = len, dcyc = 0, tk = 0, guard = 0;
    bit took = 1'b0, ended = 1'b0, claimed = 1'b0, prev_rd = 1'b0, fr_low = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before start", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_len = LW'(len); gnt_n = 1'b0;
    beat_data = wword(addr, 0); beat_be = wbe(0);
    @(negedge clk);
    req_valid = 1'b0; gnt_n = 1'b1;
    chk(frame_n_o == 1'b0 && irdy_n_o == 1'b1 && ctl_oe && ad_oe, "R2", "addr ctl",
        {28'd0, frame_n_o, irdy_n_o, ctl_oe, ad_oe}, 32'b0011);
    chk(ad_o == addr, "R2", "addr value", ad_o, addr);
    chk(cbe_n_o == cmd, "R2", "command", {28'd0, cbe_n_o}, {28'd0, cmd});
    chk(beat_take == 1'b1, "R4", "take in addr", {31'd0, beat_take}, 32'd1);
    took = 1'b1;
    while (!ended && guard < 64) begin
      bit dv, tr, sp, st_now, xf;
      guard++;
      @(negedge clk);
      if (took) tk++;
      beat_data = wword(addr, tk); beat_be = wbe(tk);
      chk(irdy_n_o == 1'b0, "R3", "irdy in data", {31'd0, irdy_n_o}, 32'd0);
      chk(frame_n_o == (rem == 1), "R5", "frame vs last", {31'd0, frame_n_o}, {31'd0, rem == 1});
      chk(ad_oe == wr, "R3", "ad_oe by direction", {31'd0, ad_oe}, {31'd0, wr});
      chk(cbe_n_o == ~wbe(moved), "R3", "byte enables", {28'd0, cbe_n_o}, {28'd0, ~wbe(moved)});
      if (wr) chk(ad_o == wword(addr, moved), "R3", "write data", ad_o, wword(addr, moved));
      chk(done == 1'b0, "R6", "no done mid burst", {31'd0, done}, 32'd0);
      chk(rd_valid == prev_rd, "R14", "rd_valid", {31'd0, rd_valid}, {31'd0, prev_rd});
      if (prev_rd) chk(rd_data == rword(addr, moved - 1), "R14", "rd_data", rd_data, rword(addr, moved - 1));
      st_now = (dcyc >= dly) && (moved == stop_at) && (!tab || dcyc > dly);
      if (tab && st_now) begin
        dv = 1'b0; tr = 1'b0; sp = 1'b1;
      end else begin
        dv = (dcyc >= dly);
        sp = st_now;
        tr = dv && (st_now ? stop_data : (!waitm || ((dcyc - dly) % 2 == 1)));
      end
      devsel_n_i = !dv; trdy_n_i = !tr; stop_n_i = !sp;
      ad_i = wr ? 32'h0 : rword(addr, moved);
      xf = dv && tr;
      fr_low = (rem > 1);
      if (tab && st_now) ended = 1'b1;
      else if (!claimed && !dv && dcyc == 3) ended = 1'b1;
      else if (xf && rem == 1) ended = 1'b1;
      else if (sp) ended = 1'b1;
      if (dv) claimed = 1'b1;
      #1;
      chk(beat_take == (xf && !ended), "R4", "beat_take", {31'd0, beat_take}, {31'd0, xf && !ended});
      took = beat_take;
      prev_rd = xf && !wr;
      if (xf) begin moved++; rem--; end
      dcyc++;
    end
    @(negedge clk);
    idle_bus();
    chk(done == 1'b1, req, "done pulse", {31'd0, done}, 32'd1);
    chk(done_code == 3'(exp_code), req, "done_code", {29'd0, done_code}, 32'(exp_code));
    chk(done_count == LW'(exp_cnt), req, "done_count", {24'd0, done_count}, 32'(exp_cnt));
    chk(rd_valid == prev_rd, "R14", "rd_valid last", {31'd0, rd_valid}, {31'd0, prev_rd});
    if (prev_rd) chk(rd_data == rword(addr, moved - 1), "R14", "rd_data last", rd_data, rword(addr, moved - 1));
    if (fr_low) begin
      chk(frame_n_o == 1'b1 && irdy_n_o == 1'b0, "R13", "release cycle",
          {30'd0, frame_n_o, irdy_n_o}, 32'b10);
      @(negedge clk);
    end
    chk(frame_n_o && irdy_n_o && ctl_oe, "R13", "both high driven",
        {29'd0, frame_n_o, irdy_n_o, ctl_oe}, 32'b111);
    @(negedge clk);
    chk(ctl_oe == 1'b0 && req_ready == 1'b1, "R6", "bus released",
        {30'd0, ctl_oe, req_ready}, 32'b01);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_len = '0;
    beat_data = '0; beat_be = '0; gnt_n = 1'b1; frame_n_i = 1'b1; irdy_n_i = 1'b1;
    idle_bus();
    repeat (3) @(negedge clk);
    chk(frame_n_o && irdy_n_o && !ctl_oe && !ad_oe && !par_oe && req_ready && !done,
        "R1", "in reset", {25'd0, frame_n_o, irdy_n_o, ctl_oe, ad_oe, par_oe, req_ready, done}, 32'b1100010);
    rst = 1'b0;
    @(negedge clk);
    chk(frame_n_o && irdy_n_o && !ctl_oe && req_ready, "R1", "after reset",
        {28'd0, frame_n_o, irdy_n_o, ctl_oe, req_ready}, 32'b1101);

    // R2: busy bus or missing grant must not start a burst.
    req_valid = 1'b1; req_cmd = 4'b0111; req_addr = 32'h100; req_len = 8'd2;
    gnt_n = 1'b0; frame_n_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(ctl_oe == 1'b0, "R2", "hold while frame busy", {31'd0, ctl_oe}, 32'd0);
    frame_n_i = 1'b1; irdy_n_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(ctl_oe == 1'b0, "R2", "hold while irdy busy", {31'd0, ctl_oe}, 32'd0);
    irdy_n_i = 1'b1; gnt_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ctl_oe == 1'b0 && req_ready, "R2", "hold without grant", {30'd0, ctl_oe, req_ready}, 32'b01);
    req_valid = 1'b0;

    run_txn(4'b0111, 32'h0000_1000, 4, 0, 1'b0, -1, 1'b0, 1'b0, 0, 4, "R6");
    run_txn(4'b0110, 32'h0000_2040, 4, 1, 1'b1, -1, 1'b0, 1'b0, 0, 4, "R14");
    run_txn(4'b0011, 32'h0000_0CF8, 1, 2, 1'b0, -1, 1'b0, 1'b0, 0, 1, "R5");
    run_txn(4'b1010, 32'h0000_0800, 3, 99, 1'b0, -1, 1'b0, 1'b0, 5, 0, "R8");
    run_txn(4'b0010, 32'h0000_0300, 1, 99, 1'b0, -1, 1'b0, 1'b0, 5, 0, "R8");
    run_txn(4'b0111, 32'h0000_3000, 4, 0, 1'b0, 0, 1'b0, 1'b0, 1, 0, "R9");
    run_txn(4'b0110, 32'h0000_4000, 5, 1, 1'b0, 2, 1'b1, 1'b0, 2, 3, "R10");
    run_txn(4'b0111, 32'h0000_5000, 5, 0, 1'b1, 2, 1'b0, 1'b0, 3, 2, "R11");
    run_txn(4'b0110, 32'h0000_6000, 4, 0, 1'b0, 1, 1'b0, 1'b1, 4, 1, "R12");
    run_txn(4'b1011, 32'h0000_7000, 2, 0, 1'b0, 1, 1'b1, 1'b0, 0, 2, "R6");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule